// File: doc/BRIEF.md
# Event Counter Bank with Overflow Interrupt

This block holds a set of event counters that software programs and reads through a simple register port. Each counter watches one 16-bit group chosen from a wide bus of processor event lines. It adds one in every cycle in which any event in that group that its mask allows is active.

A counter can be restricted so that it counts only while the current interrupt level is low enough, or it can bypass that restriction. When a counter wraps past its top value it records a sticky overflow. It can also raise an interrupt. On the first cycle of the combined interrupt, the block takes a snapshot of the program counter.

A single global enable bit starts and stops every counter at once. Software clears status flags by writing ones to them.

Top module: `pmc_bank`

## Requirements
- R1: After reset, every counter value, every control and status register, the global control register and the interrupt PC all read 0, and `irq` is low.
- R2: Bit 0 of the global control register (offset 0x1000) gates all counting. While it is 0, no counter value changes except through a software write.
- R3: Event group g occupies bits [16g+15:16g] of `evt_bus`. In a counter's control register, bits 12:8 select the group and bits 31:16 are the event mask. The counter adds exactly 1 at each clock edge where the selected group ANDed with the mask is nonzero. Events outside the mask or in other groups have no effect.
- R4: Control bits 7:4 hold a level threshold. The counter counts only while `cur_lvl` is less than or equal to that threshold, unless control bit 3 is set, which disables the level check.
- R5: A counter steps from all ones to 0 and keeps counting from there. At that step it sets bit 0 of its status register, and that bit stays set until software clears it.
- R6: On a wrap, status bit 4 is also set, but only if control bit 0 is 1. `irq` is high exactly while any counter has status bit 4 set.
- R7: Writing a status register clears each of bits 0 and 4 for which the written word has a 1. Bits written as 0 are kept.
- R8: A software write to a counter value is applied in place of any increment that falls in the same cycle.
- R9: When `irq` rises, the `pc_in` value of the first cycle in which `irq` is high is stored in the interrupt PC register (offset 0x1010). Writes to that offset are ignored.
- R10: The registers sit at these offsets:
  - counter n value at 0x1080+4n;
  - counter n control at 0x1100+4n;
  - counter n status at 0x1180+4n.
- R11: Read data appears on `reg_rdata`, with `reg_rvalid` high, one cycle after `reg_rd`. Unmapped offsets read 0. In the control register, bits 15:13 and 2:1 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 16 | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| reg_rvalid | output | 1 | Read data valid, one cycle after the read strobe |
| evt_bus | input | 512 | 32 event groups of 16 lines each |
| cur_lvl | input | 4 | Current interrupt level of the processor |
| pc_in | input | 32 | Current program counter |
| irq | output | 1 | OR of all per-counter interrupt status bits |

## Verification
The properties assume that `reg_wr` and `reg_rd` are never asserted together. They also assume that the event bus, the level and the PC change only between clock edges. The bench drives all of these inputs on the falling edge and issues one register access at a time.

Overflow is reached by preloading counter values close to all ones rather than by counting through the whole range. This keeps every wrap, and the interrupt PC snapshot that follows it, within a few cycles of a known start.

// File: rtl/pmc_pkg.sv
`timescale 1ns/1ps
package pmc_pkg;
  localparam int GRP_N = 32;
  localparam int GRP_W = 16;
  localparam int LVL_W = 4;
  localparam int SEL_W = $clog2(GRP_N);

  localparam logic [15:0] OFS_GCTRL = 16'h1000;
  localparam logic [15:0] OFS_IPC   = 16'h1010;
  localparam logic [15:0] BASE_VAL  = 16'h1080;
  localparam logic [15:0] BASE_CTL  = 16'h1100;
  localparam logic [15:0] BASE_STS  = 16'h1180;

  typedef struct packed {
    logic [GRP_W-1:0] mask;
    logic [SEL_W-1:0] grp;
    logic [LVL_W-1:0] lvl;
    logic             kern;
    logic             int_en;
  } ctl_t;

  function automatic ctl_t word_to_ctl(input logic [31:0] w);
    ctl_t c;
    c.mask   = w[31:16];
    c.grp    = w[12:8];
    c.lvl    = w[7:4];
    c.kern   = w[3];
    c.int_en = w[0];
    return c;
  endfunction

  function automatic logic [31:0] ctl_to_word(input ctl_t c);
    return {c.mask, 3'b000, c.grp, c.lvl, c.kern, 2'b00, c.int_en};
  endfunction
endpackage

// File: rtl/pmc_event_sel.sv
`timescale 1ns/1ps
module pmc_event_sel
  import pmc_pkg::*;
(
  input  logic [GRP_N*GRP_W-1:0] evt_bus,
  input  ctl_t                   ctl,
  input  logic [LVL_W-1:0]       cur_lvl,
  output logic                   hit
);
  logic [GRP_W-1:0] grp_bits;

  always_comb begin
    grp_bits = '0;
    for (int g = 0; g < GRP_N; g++) begin
      if (ctl.grp == SEL_W'(g)) grp_bits = evt_bus[g*GRP_W +: GRP_W];
    end
  end

  assign hit = (|(grp_bits & ctl.mask)) && (ctl.kern || (cur_lvl <= ctl.lvl));
endmodule

// File: rtl/pmc_counter.sv
`timescale 1ns/1ps
module pmc_counter
  import pmc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             wr_val,
  input  logic             wr_ctl,
  input  logic             wr_sts,
  input  logic [31:0]      wdata,
  output logic [CNT_W-1:0] val,
  output ctl_t             ctl,
  output logic             ovf,
  output logic             ist
);
  logic wrap;
  assign wrap = inc && (&val) && !wr_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      val <= '0;
      ctl <= '0;
      ovf <= 1'b0;
      ist <= 1'b0;
    end else begin
      if (wr_val)   val <= wdata[CNT_W-1:0];
      else if (inc) val <= val + CNT_W'(1);

      if (wr_ctl) ctl <= word_to_ctl(wdata);

      if (wrap)                     ovf <= 1'b1;
      else if (wr_sts && wdata[0])  ovf <= 1'b0;

      if (wrap && ctl.int_en)       ist <= 1'b1;
      else if (wr_sts && wdata[4])  ist <= 1'b0;
    end
  end
endmodule

// File: rtl/pmc_bank.sv
`timescale 1ns/1ps
module pmc_bank
  import pmc_pkg::*;
#(
  parameter int NUM_CTR = 8,
  parameter int CNT_W   = 32,
  parameter int PC_W    = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [15:0]            reg_addr,
  input  logic                   reg_wr,
  input  logic                   reg_rd,
  input  logic [31:0]            reg_wdata,
  output logic [31:0]            reg_rdata,
  output logic                   reg_rvalid,
  input  logic [GRP_N*GRP_W-1:0] evt_bus,
  input  logic [LVL_W-1:0]       cur_lvl,
  input  logic [PC_W-1:0]        pc_in,
  output logic                   irq
);
  localparam int IDX_W = 5;

  logic                          glob_en;
  logic [PC_W-1:0]               ipc;
  logic                          irq_d;
  logic [NUM_CTR-1:0]            sel_val, sel_ctl, sel_sts;
  logic [NUM_CTR-1:0]            wr_val, wr_ctl, wr_sts;
  logic [NUM_CTR-1:0]            hit, inc, ovf_v, ist_v;
  logic [NUM_CTR-1:0][CNT_W-1:0] cnt_v;
  ctl_t                          ctl_v [NUM_CTR];
  logic [31:0]                   rd_word;

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    localparam logic [IDX_W-1:0] IDX = IDX_W'(i);
    assign sel_val[i] = (reg_addr[15:7] == BASE_VAL[15:7]) && (reg_addr[6:2] == IDX) && (reg_addr[1:0] == 2'b00);
    assign sel_ctl[i] = (reg_addr[15:7] == BASE_CTL[15:7]) && (reg_addr[6:2] == IDX) && (reg_addr[1:0] == 2'b00);
    assign sel_sts[i] = (reg_addr[15:7] == BASE_STS[15:7]) && (reg_addr[6:2] == IDX) && (reg_addr[1:0] == 2'b00);
    assign wr_val[i]  = reg_wr && sel_val[i];
    assign wr_ctl[i]  = reg_wr && sel_ctl[i];
    assign wr_sts[i]  = reg_wr && sel_sts[i];
    assign inc[i]     = glob_en && hit[i];

    pmc_event_sel u_sel (
      .evt_bus (evt_bus),
      .ctl     (ctl_v[i]),
      .cur_lvl (cur_lvl),
      .hit     (hit[i])
    );

    pmc_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst    (rst),
      .inc    (inc[i]),
      .wr_val (wr_val[i]),
      .wr_ctl (wr_ctl[i]),
      .wr_sts (wr_sts[i]),
      .wdata  (reg_wdata),
      .val    (cnt_v[i]),
      .ctl    (ctl_v[i]),
      .ovf    (ovf_v[i]),
      .ist    (ist_v[i])
    );
  end

  assign irq = |ist_v;

  always_comb begin
    rd_word = '0;
    if (reg_addr == OFS_GCTRL) rd_word = {31'b0, glob_en};
    if (reg_addr == OFS_IPC)   rd_word = 32'(ipc);
    for (int i = 0; i < NUM_CTR; i++) begin
      if (sel_val[i]) rd_word = 32'(cnt_v[i]);
      if (sel_ctl[i]) rd_word = ctl_to_word(ctl_v[i]);
      if (sel_sts[i]) rd_word = {27'b0, ist_v[i], 3'b000, ovf_v[i]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      glob_en    <= 1'b0;
      ipc        <= '0;
      irq_d      <= 1'b0;
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == OFS_GCTRL) glob_en <= reg_wdata[0];
      irq_d <= irq;
      if (irq && !irq_d) ipc <= pc_in;
      reg_rvalid <= reg_rd;
      if (reg_rd) reg_rdata <= rd_word;
    end
  end
endmodule

// File: rtl/pmc_bank_chk.sv
`timescale 1ns/1ps
module pmc_bank_chk #(
  parameter int NUM_CTR = 8,
  parameter int CNT_W   = 32,
  parameter int PC_W    = 32
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          glob_en,
  input logic [NUM_CTR-1:0]            wr_val,
  input logic [NUM_CTR-1:0]            wr_sts,
  input logic [31:0]                   wdata,
  input logic [NUM_CTR-1:0][CNT_W-1:0] cnt_v,
  input logic [NUM_CTR-1:0]            ovf_v,
  input logic [NUM_CTR-1:0]            ist_v,
  input logic                          irq,
  input logic [PC_W-1:0]               pc_in,
  input logic [PC_W-1:0]               ipc,
  input logic                          reg_rd,
  input logic                          reg_rvalid
);
  for (genvar i = 0; i < NUM_CTR; i++) begin : g_chk
    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
      (!glob_en && !wr_val[i]) |=> $stable(cnt_v[i])); // R2
    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (rst)
      !wr_val[i] |=> (cnt_v[i] == $past(cnt_v[i]) || cnt_v[i] == $past(cnt_v[i]) + CNT_W'(1))); // R3
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
      (ovf_v[i] && !(wr_sts[i] && wdata[0])) |=> ovf_v[i]); // R5
    AST_INT_WITH_OVF: assert property (@(posedge clk) disable iff (rst)
      $rose(ist_v[i]) |-> ovf_v[i]); // R6
  end

  AST_PC_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |=> (ipc == $past(pc_in))); // R9
  AST_RVALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> reg_rvalid); // R11
endmodule

bind pmc_bank pmc_bank_chk #(.NUM_CTR(NUM_CTR), .CNT_W(CNT_W), .PC_W(PC_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .glob_en    (glob_en),
  .wr_val     (wr_val),
  .wr_sts     (wr_sts),
  .wdata      (reg_wdata),
  .cnt_v      (cnt_v),
  .ovf_v      (ovf_v),
  .ist_v      (ist_v),
  .irq        (irq),
  .pc_in      (pc_in),
  .ipc        (ipc),
  .reg_rd     (reg_rd),
  .reg_rvalid (reg_rvalid)
);

// File: tb/tb_pmc_bank.sv
`timescale 1ns/1ps
module tb_pmc_bank;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [15:0]  reg_addr = '0;
  logic         reg_wr = 1'b0;
  logic         reg_rd = 1'b0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic         reg_rvalid;
  logic [511:0] evt_bus = '0;
  logic [3:0]   cur_lvl = '0;
  logic [31:0]  pc_in = 32'h4000_1234;
  logic         irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  typedef struct {
    logic [31:0] exp;
    logic [15:0] addr;
    string       req;
  } item_t;
  item_t sbq[$];

  always #2.5 clk = ~clk;

  pmc_bank dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .evt_bus(evt_bus), .cur_lvl(cur_lvl), .pc_in(pc_in), .irq(irq)
  );

  function automatic logic [15:0] a_val(int n); return 16'(16'h1080 + 4*n); endfunction
  function automatic logic [15:0] a_ctl(int n); return 16'(16'h1100 + 4*n); endfunction
  function automatic logic [15:0] a_sts(int n); return 16'(16'h1180 + 4*n); endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a, input logic [31:0] exp, input string req);
    item_t it;
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    it.exp = exp; it.addr = a; it.req = req;
    sbq.push_back(it);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic set_grp(input int g, input logic [15:0] bits);
    evt_bus[g*16 +: 16] = bits;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && reg_rvalid) begin
      if (sbq.size() == 0) begin
        n_checks++; n_fail++;
        $display("FAIL R11: unexpected read data %h expected none", reg_rdata);
      end else begin
        item_t it;
        it = sbq.pop_front();
        n_checks++;
        if (reg_rdata !== it.exp) begin
          n_fail++;
          $display("FAIL %s: addr %h actual %h expected %h", it.req, it.addr, reg_rdata, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk({31'b0, irq}, 32'h0, "R1 irq");
    bus_read(16'h1000, 32'h0, "R1 gctrl");
    bus_read(a_val(0), 32'h0, "R1 value");
    bus_read(a_ctl(3), 32'h0, "R1 control");
    bus_read(a_sts(7), 32'h0, "R1 status");
    bus_read(16'h1010, 32'h0, "R1 ipc");

    // counters 0..2 on groups 3/4
    bus_write(a_ctl(0), 32'h0001_0308);
    bus_write(a_ctl(1), 32'h0002_0308);
    bus_write(a_ctl(2), 32'h0001_0408);

    // R2 global disable blocks counting
    @(negedge clk); set_grp(3, 16'h0001);
    repeat (5) @(negedge clk);
    set_grp(3, 16'h0000);
    bus_read(a_val(0), 32'h0, "R2 no count while disabled");

    // R3 counting, mask and group selection
    bus_write(16'h1000, 32'h1);
    @(negedge clk); set_grp(3, 16'h0001);
    repeat (10) @(negedge clk);
    set_grp(3, 16'h0000);
    bus_read(a_val(0), 32'd10, "R3 count 10");
    bus_read(a_val(1), 32'd0, "R3 masked bit ignored");
    bus_read(a_val(2), 32'd0, "R3 other group ignored");

    // R4 level filter and bypass
    bus_write(a_ctl(3), 32'h0080_0520);
    bus_write(a_ctl(4), 32'h0080_0528);
    @(negedge clk); cur_lvl = 4'd3; set_grp(5, 16'h0080);
    repeat (6) @(negedge clk);
    cur_lvl = 4'd2;
    repeat (4) @(negedge clk);
    set_grp(5, 16'h0000); cur_lvl = 4'd0;
    bus_read(a_val(3), 32'd4, "R4 level filter");
    bus_read(a_val(4), 32'd10, "R4 level bypass");

    // R5/R6/R9 overflow, interrupt, PC snapshot
    bus_write(a_val(5), 32'hFFFF_FFFE);
    bus_write(a_val(6), 32'hFFFF_FFFF);
    bus_write(a_ctl(5), 32'hFFFF_0609);
    bus_write(a_ctl(6), 32'h8000_0608);
    chk({31'b0, irq}, 32'h0, "R6 irq low before wrap");
    @(negedge clk); set_grp(6, 16'h8000);
    repeat (2) @(negedge clk);
    set_grp(6, 16'h0000);
    repeat (3) @(negedge clk);
    pc_in = 32'hDEAD_0000;
    chk({31'b0, irq}, 32'h1, "R6 irq high after wrap");
    bus_read(a_val(5), 32'h0, "R5 wrap to zero");
    bus_read(a_sts(5), 32'h11, "R6 ovf and int set");
    bus_read(a_val(6), 32'h1, "R5 counts on after wrap");
    bus_read(a_sts(6), 32'h01, "R6 no int when disabled");
    bus_read(16'h1010, 32'h4000_1234, "R9 pc captured");

    // R7 write-one-to-clear
    bus_write(a_sts(5), 32'h10);
    chk({31'b0, irq}, 32'h0, "R7 irq drops after clear");
    bus_read(a_sts(5), 32'h01, "R7 clear int only");
    bus_write(a_sts(5), 32'h01);
    bus_read(a_sts(5), 32'h00, "R7 clear ovf");

    // R8 write beats increment
    bus_write(a_ctl(7), 32'hFFFF_0708);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a_val(7); reg_wdata = 32'h100; set_grp(7, 16'h0001);
    @(negedge clk);
    reg_wr = 1'b0; set_grp(7, 16'h0000);
    bus_read(a_val(7), 32'h100, "R8 write priority");

    // R11 control readback, unmapped reads; R9 ipc read-only
    bus_write(a_ctl(1), 32'hFFFF_FFFF);
    bus_read(a_ctl(1), 32'hFFFF_1FF9, "R11 reserved bits zero");
    bus_write(16'h1010, 32'h5555);
    bus_read(16'h1010, 32'h4000_1234, "R9 ipc write ignored");
    bus_read(16'h1004, 32'h0, "R11 unmapped zero");
    bus_read(16'h1000, 32'h1, "R10 gctrl readback");

    // R2 disable again
    bus_write(16'h1000, 32'h0);
    @(negedge clk); set_grp(7, 16'h0001);
    repeat (4) @(negedge clk);
    set_grp(7, 16'h0000);
    bus_read(a_val(7), 32'h100, "R2 stopped after disable");

    repeat (3) @(negedge clk);
    chk(32'(sbq.size()), 32'h0, "R11 all reads returned");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule